// File: doc/BRIEF.md
# Multi-Channel Doorbell Mailbox

This block links a host processor and a remote controller through a set of independent mailbox channels. Each channel owns an outbound buffer (host to remote), an inbound buffer (remote to host), a host control word and a remote status word. Single-bit handshake flags in those words pass one message at a time in each direction. A per-channel interrupt tells the host that the remote has posted a reply.

Both sides reach the block through a simple 32-bit register port with a write strobe and combinational read data. The address is a channel index in the upper bits above a window offset, so every channel appears as its own window. The offsets are the same on the host and remote ports. Only the side that owns a location may change it. The host owns the outbound buffer and the control word. The remote owns the inbound buffer and the status word.

A message moves outbound in four steps. The host fills the sixteen outbound words, then sets the pending flag. The remote reads the message and acknowledges it, which frees the buffer. A reply moves inbound the same way. The remote fills the inbound words, then sets the reply-ready flag. The host reads the reply and writes the consumed flag, and the block clears both flags one cycle later.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset every control flag, every buffer word and every interrupt line is zero.
- R2: Offset 0x0 of each window reads back the channel index. Writes to it have no effect.
- R3: Host writes to outbound words at offsets 0x800 + 4*i (i from 0 to 15) are readable at the same offsets from both the host and the remote port.
- R4: In the host control word at offset 0x4, writing 1 to bit 0 sets the outbound-pending flag. Writing 0 to bit 0 leaves the flag unchanged. The flag reads back on bit 0 from both ports.
- R5: While outbound-pending is set, host writes to the outbound buffer leave the stored words unchanged and set a sticky error flag. The error flag reads on bit 12 of the host control word.
- R6: A remote write of 1 to bit 1 at offset 0x8 clears outbound-pending.
- R7: The remote loads inbound words at offsets 0x1000 + 4*i. A remote write of 1 to bit 0 at offset 0x8 sets reply-ready. Reply-ready reads on bit 0 of offset 0x8, and the host can read the inbound words.
- R8: The interrupt line of a channel is high exactly while that channel's reply-ready flag and interrupt-enable flag are both set. Interrupt-enable is bit 8 of the host control word.
- R9: A host write of 1 to bit 4 of the host control word sets the consumed flag. One clock edge later, the block clears both consumed and reply-ready, so the interrupt is still high for one cycle after the write and low after that.
- R10: Writing the value zero to the host control word clears outbound-pending, consumed, interrupt-enable and the error flag.
- R11: Reads of offsets that no register uses return zero. Activity on one channel leaves the other channels unchanged.
- R12: Remote writes to the inbound buffer are ignored while reply-ready is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | CH_BITS+WIN_BITS | Host byte address (channel index, then window offset) |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr, combinational |
| r_addr | input | CH_BITS+WIN_BITS | Remote byte address, same layout as the host address |
| r_wr | input | 1 | Remote write strobe |
| r_wdata | input | 32 | Remote write data |
| r_rdata | output | 32 | Remote read data for r_addr, combinational |
| irq | output | 2**CH_BITS | One host interrupt line per channel |

## Verification
The assertions assume that every flag change is caused by a write on one of the two ports. They also assume that an error is only raised against a pending outbound message. So the stimulus never holds a write strobe high for more than the single cycle the driver task intends. The bench also keeps the host and remote ports from writing in the same cycle, so each flag change has one clear cause. The expected values come from the register layout and the one-cycle delay on the consumed flag. They cover a single reply path, on the channel the bench exercises, and a second channel whose interrupt is still disabled when its reply arrives.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int CH_BITS  = 3,
  parameter int WIN_BITS = 16,
  parameter int WORDS    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CH_BITS+WIN_BITS-1:0] h_addr,
  input  logic                        h_wr,
  input  logic [31:0]                 h_wdata,
  output logic [31:0]                 h_rdata,
  input  logic [CH_BITS+WIN_BITS-1:0] r_addr,
  input  logic                        r_wr,
  input  logic [31:0]                 r_wdata,
  output logic [31:0]                 r_rdata,
  output logic [(1<<CH_BITS)-1:0]     irq
);
  localparam int NCH = 1 << CH_BITS;
  localparam int WB  = $clog2(WORDS);
  localparam int IW  = CH_BITS + WB;
  localparam logic [WIN_BITS-1:0] OFF_ID   = WIN_BITS'(0);
  localparam logic [WIN_BITS-1:0] OFF_HCTL = WIN_BITS'(4);
  localparam logic [WIN_BITS-1:0] OFF_RCTL = WIN_BITS'(8);
  localparam logic [WIN_BITS-1:0] OFF_OUT  = WIN_BITS'('h800);
  localparam logic [WIN_BITS-1:0] OFF_IN   = WIN_BITS'('h1000);
  localparam logic [WIN_BITS-1:0] IDX_MASK = WIN_BITS'(WORDS*4-4);

  logic [31:0] obuf [NCH*WORDS];
  logic [31:0] ibuf [NCH*WORDS];
  logic [NCH-1:0] iv, od, ie, err, ov;

  logic [CH_BITS-1:0]  hch, rch;
  logic [WIN_BITS-1:0] hoff, roff;
  logic [IW-1:0]       hidx, ridx;

  assign hch  = h_addr[CH_BITS+WIN_BITS-1:WIN_BITS];
  assign hoff = h_addr[WIN_BITS-1:0];
  assign rch  = r_addr[CH_BITS+WIN_BITS-1:WIN_BITS];
  assign roff = r_addr[WIN_BITS-1:0];
  assign hidx = {hch, hoff[WB+1:2]};
  assign ridx = {rch, roff[WB+1:2]};

  wire h_out = (hoff & ~IDX_MASK) == OFF_OUT;
  wire r_in  = (roff & ~IDX_MASK) == OFF_IN;

  assign irq = ov & ie;

  function automatic logic [31:0] rd_word(logic [CH_BITS-1:0] ch,
                                          logic [WIN_BITS-1:0] off,
                                          logic [IW-1:0] idx);
    logic [31:0] v;
    v = '0;
    if (off == OFF_ID)        v = 32'(ch);
    else if (off == OFF_HCTL) v = {19'b0, err[ch], 3'b0, ie[ch], 3'b0, od[ch], 3'b0, iv[ch]};
    else if (off == OFF_RCTL) v = {31'b0, ov[ch]};
    else if ((off & ~IDX_MASK) == OFF_OUT) v = obuf[idx];
    else if ((off & ~IDX_MASK) == OFF_IN)  v = ibuf[idx];
    return v;
  endfunction

  assign h_rdata = rd_word(hch, hoff, hidx);
  assign r_rdata = rd_word(rch, roff, ridx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv <= '0; od <= '0; ie <= '0; err <= '0; ov <= '0;
      for (int i = 0; i < NCH*WORDS; i++) begin
        obuf[i] <= '0;
        ibuf[i] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (od[c]) begin
          od[c] <= 1'b0;
          ov[c] <= 1'b0;
        end else if (r_wr && rch == CH_BITS'(c) && roff == OFF_RCTL && r_wdata[0]) begin
          ov[c] <= 1'b1;
        end
        if (r_wr && rch == CH_BITS'(c) && roff == OFF_RCTL && r_wdata[1])
          iv[c] <= 1'b0;
        if (h_wr && hch == CH_BITS'(c) && hoff == OFF_HCTL) begin
          if (h_wdata == 32'b0) begin
            iv[c] <= 1'b0; od[c] <= 1'b0; ie[c] <= 1'b0; err[c] <= 1'b0;
          end else begin
            ie[c] <= h_wdata[8];
            if (h_wdata[0]) iv[c] <= 1'b1;
            if (h_wdata[4]) od[c] <= 1'b1;
          end
        end
        if (h_wr && hch == CH_BITS'(c) && h_out && iv[c])
          err[c] <= 1'b1;
      end
      if (h_wr && h_out && !iv[hch]) obuf[hidx] <= h_wdata;
      if (r_wr && r_in && !ov[rch])  ibuf[ridx] <= r_wdata;
    end
  end
endmodule

module mbox_doorbell_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           h_wr,
  input logic           r_wr,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] iv,
  input logic [NCH-1:0] od,
  input logic [NCH-1:0] ov,
  input logic [NCH-1:0] err
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      od[c] |=> (!ov[c] && !od[c]));
    // R5
    err_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err[c]) |-> $past(iv[c]));
    // R4
    pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iv[c] && !h_wr && !r_wr) |=> iv[c]);
    // R7
    reply_by_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov[c]) |-> $past(r_wr));
    // R8
    irq_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(h_wr || r_wr));
  end
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .r_wr(r_wr), .irq(irq),
  .iv(iv), .od(od), .ov(ov), .err(err)
);

// File: tb/mbox_doorbell_bench.sv
module mbox_doorbell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] h_addr = '0, r_addr = '0;
  logic h_wr = 0, r_wr = 0;
  logic [31:0] h_wdata = '0, r_wdata = '0, h_rdata, r_rdata;
  logic [7:0] irq;

  int checks = 0, errors = 0, cycles = 0;
  logic chk_v = 0;
  logic [31:0] exp_q[$];
  int sel_q[$];
  string tag_q[$];

  mbox_doorbell u_mbox_doorbell (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] A(int c, int off);
    return {3'(c), 16'(off)};
  endfunction

  always @(negedge clk) begin
    if (chk_v && exp_q.size() > 0) begin
      logic [31:0] e, a;
      int s;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      a = (s == 0) ? h_rdata : (s == 1) ? r_rdata : {24'b0, irq};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic expect_at(int s, logic [AW-1:0] ad, logic [31:0] e, string t);
    if (s == 0) h_addr = ad; else if (s == 1) r_addr = ad;
    exp_q.push_back(e); sel_q.push_back(s); tag_q.push_back(t);
    chk_v = 1;
    @(posedge clk); #1 chk_v = 0;
  endtask

  task automatic hw(logic [AW-1:0] ad, logic [31:0] d);
    h_addr = ad; h_wdata = d; h_wr = 1;
    @(posedge clk); #1 h_wr = 0;
  endtask

  task automatic rw(logic [AW-1:0] ad, logic [31:0] d);
    r_addr = ad; r_wdata = d; r_wr = 1;
    @(posedge clk); #1 r_wr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    expect_at(2, '0, 32'h0, "R1 irq after reset");
    expect_at(0, A(0, 'h4), 32'h0, "R1 host ctrl after reset");
    expect_at(0, A(3, 'h814), 32'h0, "R1 outbound word after reset");
    expect_at(1, A(6, 'h1000), 32'h0, "R1 inbound word after reset");
    expect_at(0, A(5, 'h0), 32'h5, "R2 channel id");
    hw(A(5, 'h0), 32'hFFFF_FFFF);
    expect_at(0, A(5, 'h0), 32'h5, "R2 id write ignored");
    for (int i = 0; i < 16; i++) hw(A(2, 'h800 + 4*i), 32'hA000_0000 + i*32'h111);
    expect_at(1, A(2, 'h800), 32'hA000_0000, "R3 remote reads word 0");
    expect_at(1, A(2, 'h83C), 32'hA000_0FFF, "R3 remote reads word 15");
    expect_at(0, A(2, 'h81C), 32'hA000_0777, "R3 host reads word 7");
    hw(A(2, 'h4), 32'h101);
    expect_at(1, A(2, 'h4), 32'h101, "R4 pending visible to remote");
    hw(A(2, 'h4), 32'h100);
    expect_at(0, A(2, 'h4), 32'h100 | 32'h1, "R4 writing 0 to bit 0 keeps pending");
    hw(A(2, 'h800), 32'hDEAD);
    expect_at(1, A(2, 'h800), 32'hA000_0000, "R5 write while pending ignored");
    expect_at(0, A(2, 'h4), 32'h1101, "R5 sticky error set");
    rw(A(2, 'h8), 32'h2);
    expect_at(0, A(2, 'h4), 32'h1100, "R6 remote ack clears pending");
    for (int i = 0; i < 16; i++) rw(A(2, 'h1000 + 4*i), 32'hB000_0000 + i);
    rw(A(2, 'h8), 32'h1);
    expect_at(2, '0, 32'h04, "R8 irq on reply with enable");
    expect_at(0, A(2, 'h8), 32'h1, "R7 reply-ready seen by host");
    expect_at(0, A(2, 'h100C), 32'hB000_0003, "R7 host reads inbound word 3");
    rw(A(2, 'h100C), 32'h5555);
    expect_at(0, A(2, 'h100C), 32'hB000_0003, "R12 inbound write while ready ignored");
    hw(A(2, 'h4), 32'h110);
    expect_at(2, '0, 32'h04, "R9 irq still high one cycle after done");
    expect_at(0, A(2, 'h4), 32'h1100, "R9 done self-clears");
    expect_at(1, A(2, 'h8), 32'h0, "R9 reply-ready cleared");
    expect_at(2, '0, 32'h0, "R9 irq low");
    hw(A(2, 'h4), 32'h0);
    expect_at(0, A(2, 'h4), 32'h0, "R10 zero write clears control");
    rw(A(4, 'h8), 32'h1);
    expect_at(2, '0, 32'h0, "R8 no irq while disabled");
    hw(A(4, 'h4), 32'h100);
    expect_at(2, '0, 32'h10, "R8 irq after enable");
    expect_at(0, A(4, 'hC), 32'h0, "R11 unmapped offset 0xC");
    expect_at(1, A(4, 'h900), 32'h0, "R11 unmapped offset 0x900");
    expect_at(0, A(4, 'h840), 32'h0, "R11 past outbound buffer");
    expect_at(0, A(3, 'h4), 32'h0, "R11 other channel untouched");
    expect_at(0, A(3, 'h808), 32'h0, "R11 other channel buffer untouched");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule